// File: doc/BRIEF.md
# Single-Stage Instruction Decode and Execute Unit

This unit takes one 32-bit instruction word of a small load/store RISC instruction set, together with its program counter and the two source operand values already read from the register file, and produces every execute-stage result of that instruction in one clocked stage. Register 0 of the attached register file always reads as zero and is never written.

The outputs cover four areas: a register write-back (index, enable, value), a change of control flow (taken flag and target address), a memory request (read or write strobe, size code, address, store data), and status flags. The status flags are illegal instruction, misaligned address, and "not handled here" for instruction kinds that belong to a separate multiply/divide or configuration unit. Signed literals are built by joining fields that are not next to each other. The 8-bit C field always forms the most significant part. Branch and jump offsets count in 4-byte words from the address of the next instruction.

The unit is used as the execute stage of a short in-order pipeline. The fetch stage supplies the word and PC, the register file supplies the operands, and the memory stage consumes the request one cycle later.

Top module: `insn_exec_unit`

## Requirements
- R1: While rstN is low, every output is zero.
- R2: The instruction fields are kind[31:26], sub[25:23], D[22:18], A[17:13], C[12:5] and B[4:0]. The literals are formed as follows:
  - The CB literal is {C,B}, sign-extended from 13 bits.
  - The CD literal is {C,D}, sign-extended from 13 bits.
  - The wide literal is {C,sub,A,B}, sign-extended from 21 bits.
- R3: Kind 0x10 computes srcA op srcB, and kind 0x11 computes srcA op (CB literal). The sub codes are:
  - 0 = and, 1 = or, 2 = xor, 3 = logical left shift by the low 5 bits of the second operand;
  - 4 = add, 5 = sub (srcA minus second operand);
  - 6 = signed less-than, 7 = unsigned less-than, each giving 1 or 0.
- R4: Every result appears on the outputs one clock edge after the inputs are sampled. Instructions that produce a register result assert destWe with destIdx = D, except that destWe stays low when D is 0.
- R5: Kind 0x14 is a conditional branch comparing srcA with srcB. The sub codes are 0 = eq, 1 = ne, 2 = signed lt, 3 = signed ge, 4 = unsigned lt, 5 = unsigned ge. When the condition holds, flowTaken is 1 and flowTarget = pc + 4 + 4 × (CD literal). A branch writes no register.
- R6: A branch with sub code 6 or 7 raises excIllegal and is not taken.
- R7: The jump kinds both write the link value pc + 4 to D and always set flowTaken:
  - kind 0x15 targets pc + 4 + 4 × (wide literal);
  - kind 0x16 targets srcA + 4 × (CB literal).
- R8: Kind 0x17 writes (wide literal) shifted left by 11 to D. Kind 0x18 writes pc + (wide literal) to D.
- R9: Kind 0x12 is a load from srcA + (CB literal) with size code sub (0 = byte, 1 = halfword, 2 = word). It asserts memRd, drives memAddr and memSize, and leaves destWe low, since the value arrives later.
- R10: Kind 0x13 is a store to srcA + (CD literal) with size code sub. It asserts memWr and drives memData = srcB. The B field does not enter the address.
- R11: A halfword access with an odd address, or a word access whose address is not a multiple of 4, raises excMisalign and suppresses memRd and memWr. Byte accesses are never misaligned.
- R12: Any kind outside 0x10 to 0x1B, and a load or store with size code 3 or more, raise excIllegal. Such an instruction writes no register, takes no branch and makes no memory request.
- R13: Kinds 0x19, 0x1A and 0x1B raise notHandled without excIllegal, and produce no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| srcA | input | 32 | Value of register A |
| srcB | input | 32 | Value of register B |
| destIdx | output | 5 | Destination register index |
| destWe | output | 1 | Register write enable |
| destVal | output | 32 | Register write value |
| flowTaken | output | 1 | Branch or jump taken |
| flowTarget | output | 32 | Target address when taken, else 0 |
| memRd | output | 1 | Load request |
| memWr | output | 1 | Store request |
| memSize | output | 2 | Access size code |
| memAddr | output | 32 | Access address for load/store kinds, else 0 |
| memData | output | 32 | Store data |
| excIllegal | output | 1 | Illegal instruction |
| excMisalign | output | 1 | Misaligned access |
| notHandled | output | 1 | Kind executed by another unit |

## Verification
Every output of this unit is due exactly one rising edge after the instruction, PC and operands are presented: no result takes longer and none is visible earlier. The bench drives each stimulus on a falling edge, lets the single register stage capture it on the next rising edge, and reads all outputs on the following falling edge, so each check sees the result of exactly one instruction. Literal tests put single set bits into separate fields to confirm where each field lands in the assembled literal.

// File: rtl/insn_exec_pkg.sv
package insn_exec_pkg;
  localparam int XLEN   = 32;
  localparam int REG_W  = 5;
  localparam int KIND_W = 6;
  localparam int SUB_W  = 3;
  localparam int CF_W   = 8;
  localparam int SZ_W   = 2;
  localparam int LIT_S  = CF_W + REG_W;          // short literal width
  localparam int LIT_W  = CF_W + SUB_W + 2*REG_W; // wide literal width
  localparam int UP_SH  = XLEN - LIT_W;          // upper-literal shift

  localparam logic [KIND_W-1:0] K_ALU_RR = 6'h10;
  localparam logic [KIND_W-1:0] K_ALU_LT = 6'h11;
  localparam logic [KIND_W-1:0] K_LOAD   = 6'h12;
  localparam logic [KIND_W-1:0] K_STORE  = 6'h13;
  localparam logic [KIND_W-1:0] K_BRANCH = 6'h14;
  localparam logic [KIND_W-1:0] K_JREL   = 6'h15;
  localparam logic [KIND_W-1:0] K_JREG   = 6'h16;
  localparam logic [KIND_W-1:0] K_UPPER  = 6'h17;
  localparam logic [KIND_W-1:0] K_PCREL  = 6'h18;
  localparam logic [KIND_W-1:0] K_EXT_LO = 6'h19;
  localparam logic [KIND_W-1:0] K_EXT_HI = 6'h1B;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [SUB_W-1:0]  sub;
    logic [REG_W-1:0]  d;
    logic [REG_W-1:0]  a;
    logic [CF_W-1:0]   c;
    logic [REG_W-1:0]  b;
  } insnFields_t;

  typedef enum logic [2:0] {
    ALU_AND, ALU_OR, ALU_XOR, ALU_SHL, ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU
  } aluOp_e;

  typedef enum logic [1:0] {LIT_CB, LIT_CD, LIT_WIDE} litSel_e;

  typedef enum logic [1:0] {RES_ALU, RES_LINK, RES_UPPER, RES_PCREL} resSel_e;

  typedef struct packed {
    aluOp_e           aluOp;
    logic             useLit;
    litSel_e          litSel;
    resSel_e          resSel;
    logic             regWrite;
    logic             isBranch;
    logic [SUB_W-1:0] cond;
    logic             isJump;
    logic             jumpViaReg;
    logic             memLoad;
    logic             memStore;
    logic [SZ_W-1:0]  memSize;
    logic             illegal;
    logic             unhandled;
  } strobes_t;
endpackage

// File: rtl/insn_exec_ctrl.sv
module insn_exec_ctrl
  import insn_exec_pkg::*;
(
  input  insnFields_t fields,
  output strobes_t    strobes
);
  localparam logic [SUB_W-1:0] MAX_SIZE = 3'd2;
  localparam logic [SUB_W-1:0] MAX_COND = 3'd5;

  always_comb begin
    strobes = '0;
    strobes.aluOp  = ALU_ADD;
    strobes.litSel = LIT_CB;
    strobes.resSel = RES_ALU;
    unique case (fields.kind)
      K_ALU_RR, K_ALU_LT: begin
        strobes.aluOp    = aluOp_e'(fields.sub);
        strobes.useLit   = (fields.kind == K_ALU_LT);
        strobes.regWrite = 1'b1;
      end
      K_LOAD, K_STORE: begin
        if (fields.sub <= MAX_SIZE) begin
          strobes.memLoad  = (fields.kind == K_LOAD);
          strobes.memStore = (fields.kind == K_STORE);
          strobes.memSize  = fields.sub[SZ_W-1:0];
          strobes.litSel   = (fields.kind == K_STORE) ? LIT_CD : LIT_CB;
        end else begin
          strobes.illegal = 1'b1;
        end
      end
      K_BRANCH: begin
        if (fields.sub <= MAX_COND) begin
          strobes.isBranch = 1'b1;
          strobes.cond     = fields.sub;
          strobes.litSel   = LIT_CD;
        end else begin
          strobes.illegal = 1'b1;
        end
      end
      K_JREL, K_JREG: begin
        strobes.isJump     = 1'b1;
        strobes.jumpViaReg = (fields.kind == K_JREG);
        strobes.litSel     = (fields.kind == K_JREG) ? LIT_CB : LIT_WIDE;
        strobes.resSel     = RES_LINK;
        strobes.regWrite   = 1'b1;
      end
      K_UPPER: begin
        strobes.litSel   = LIT_WIDE;
        strobes.resSel   = RES_UPPER;
        strobes.regWrite = 1'b1;
      end
      K_PCREL: begin
        strobes.litSel   = LIT_WIDE;
        strobes.resSel   = RES_PCREL;
        strobes.regWrite = 1'b1;
      end
      default: begin
        if (fields.kind >= K_EXT_LO && fields.kind <= K_EXT_HI)
          strobes.unhandled = 1'b1;
        else
          strobes.illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/insn_exec_dpath.sv
module insn_exec_dpath
  import insn_exec_pkg::*;
(
  input  insnFields_t      fields,
  input  strobes_t         strobes,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  output logic [REG_W-1:0] wrIdx,
  output logic             wrEn,
  output logic [XLEN-1:0]  wrVal,
  output logic             taken,
  output logic [XLEN-1:0]  target,
  output logic             rdReq,
  output logic             wrReq,
  output logic [SZ_W-1:0]  size,
  output logic [XLEN-1:0]  addr,
  output logic [XLEN-1:0]  stData,
  output logic             misalign,
  output logic             illegal,
  output logic             unhandled
);
  localparam int NUM_SIZES = 3;

  logic [XLEN-1:0]  litCb, litCd, litWide, litSel, opB, aluRes;
  logic [XLEN-1:0]  nextPc, wordOff, rawTarget, accAddr;
  logic [LIT_W-1:0] wideRaw;
  logic             condTrue, isMem;
  logic [NUM_SIZES-1:0] sizeBad;

  assign wideRaw = {fields.c, fields.sub, fields.a, fields.b};
  assign litCb   = {{(XLEN-LIT_S){fields.c[CF_W-1]}}, fields.c, fields.b};
  assign litCd   = {{(XLEN-LIT_S){fields.c[CF_W-1]}}, fields.c, fields.d};
  assign litWide = {{(XLEN-LIT_W){fields.c[CF_W-1]}}, wideRaw};

  always_comb begin
    unique case (strobes.litSel)
      LIT_CD:   litSel = litCd;
      LIT_WIDE: litSel = litWide;
      default:  litSel = litCb;
    endcase
  end

  assign opB = strobes.useLit ? litCb : srcB;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_AND:  aluRes = srcA & opB;
      ALU_OR:   aluRes = srcA | opB;
      ALU_XOR:  aluRes = srcA ^ opB;
      ALU_SHL:  aluRes = srcA << opB[4:0];
      ALU_ADD:  aluRes = srcA + opB;
      ALU_SUB:  aluRes = srcA - opB;
      ALU_SLT:  aluRes = {{(XLEN-1){1'b0}}, $signed(srcA) < $signed(opB)};
      default:  aluRes = {{(XLEN-1){1'b0}}, srcA < opB};
    endcase
  end

  always_comb begin
    unique case (strobes.cond)
      3'd0:    condTrue = (srcA == srcB);
      3'd1:    condTrue = (srcA != srcB);
      3'd2:    condTrue = ($signed(srcA) <  $signed(srcB));
      3'd3:    condTrue = ($signed(srcA) >= $signed(srcB));
      3'd4:    condTrue = (srcA <  srcB);
      default: condTrue = (srcA >= srcB);
    endcase
  end

  assign nextPc    = pc + XLEN'(4);
  assign wordOff   = litSel << 2;
  assign rawTarget = (strobes.jumpViaReg ? srcA : nextPc) + wordOff;
  assign taken     = strobes.isJump | (strobes.isBranch & condTrue);
  assign target    = taken ? rawTarget : '0;

  assign isMem   = strobes.memLoad | strobes.memStore;
  assign accAddr = srcA + litSel;

  // one alignment test per size code: size s needs its low s address bits clear
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_align
    if (s == 0) begin : g_byte
      assign sizeBad[s] = 1'b0;
    end else begin : g_wide
      assign sizeBad[s] = (strobes.memSize == SZ_W'(s)) && (|accAddr[s-1:0]);
    end
  end

  assign misalign = isMem & (|sizeBad);
  assign rdReq    = strobes.memLoad  & ~misalign;
  assign wrReq    = strobes.memStore & ~misalign;
  assign size     = strobes.memSize;
  assign addr     = isMem ? accAddr : '0;
  assign stData   = strobes.memStore ? srcB : '0;

  always_comb begin
    unique case (strobes.resSel)
      RES_LINK:  wrVal = nextPc;
      RES_UPPER: wrVal = litWide << UP_SH;
      RES_PCREL: wrVal = pc + litWide;
      default:   wrVal = aluRes;
    endcase
  end

  assign wrIdx     = fields.d;
  assign wrEn      = strobes.regWrite & (fields.d != '0);
  assign illegal   = strobes.illegal;
  assign unhandled = strobes.unhandled;
endmodule

// File: rtl/insn_exec_unit.sv
module insn_exec_unit
  import insn_exec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  output logic [4:0]  destIdx,
  output logic        destWe,
  output logic [31:0] destVal,
  output logic        flowTaken,
  output logic [31:0] flowTarget,
  output logic        memRd,
  output logic        memWr,
  output logic [1:0]  memSize,
  output logic [31:0] memAddr,
  output logic [31:0] memData,
  output logic        excIllegal,
  output logic        excMisalign,
  output logic        notHandled
);
  insnFields_t      fields;
  strobes_t         strobes;
  logic [REG_W-1:0] wrIdx;
  logic             wrEn, taken, rdReq, wrReq, misalign, illegal, unhandled;
  logic [XLEN-1:0]  wrVal, target, addr, stData;
  logic [SZ_W-1:0]  size;

  assign fields = insnFields_t'(instr);

  insn_exec_ctrl u_ctrl (.fields(fields), .strobes(strobes));

  insn_exec_dpath u_dpath (
    .fields(fields), .strobes(strobes), .pc(pc), .srcA(srcA), .srcB(srcB),
    .wrIdx(wrIdx), .wrEn(wrEn), .wrVal(wrVal), .taken(taken), .target(target),
    .rdReq(rdReq), .wrReq(wrReq), .size(size), .addr(addr), .stData(stData),
    .misalign(misalign), .illegal(illegal), .unhandled(unhandled)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destIdx     <= '0;
      destWe      <= 1'b0;
      destVal     <= '0;
      flowTaken   <= 1'b0;
      flowTarget  <= '0;
      memRd       <= 1'b0;
      memWr       <= 1'b0;
      memSize     <= '0;
      memAddr     <= '0;
      memData     <= '0;
      excIllegal  <= 1'b0;
      excMisalign <= 1'b0;
      notHandled  <= 1'b0;
    end else begin
      destIdx     <= wrIdx;
      destWe      <= wrEn;
      destVal     <= wrVal;
      flowTaken   <= taken;
      flowTarget  <= target;
      memRd       <= rdReq;
      memWr       <= wrReq;
      memSize     <= size;
      memAddr     <= addr;
      memData     <= stData;
      excIllegal  <= illegal;
      excMisalign <= misalign;
      notHandled  <= unhandled;
    end
  end
endmodule

// File: rtl/insn_exec_unit_chk.sv
module insn_exec_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instr,
  input logic [4:0]  destIdx,
  input logic        destWe,
  input logic        flowTaken,
  input logic        memRd,
  input logic        memWr,
  input logic [1:0]  memSize,
  input logic [31:0] memAddr,
  input logic        excIllegal,
  input logic        excMisalign,
  input logic        notHandled
);
  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R4
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    destWe |-> destIdx != 5'd0);

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    excIllegal |-> !destWe && !flowTaken && !memRd && !memWr && !notHandled);

  // R11
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> !((memSize == 2'd1 && memAddr[0]) ||
                           (memSize == 2'd2 && memAddr[1:0] != 2'd0)));

  // R11
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    excMisalign |-> !memRd && !memWr && memSize != 2'd0);

  // R9
  one_mem_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R7
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && ($past(instr[31:26]) == 6'h15 || $past(instr[31:26]) == 6'h16))
      |-> flowTaken);
endmodule

bind insn_exec_unit insn_exec_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .instr(instr), .destIdx(destIdx), .destWe(destWe),
  .flowTaken(flowTaken), .memRd(memRd), .memWr(memWr), .memSize(memSize),
  .memAddr(memAddr), .excIllegal(excIllegal), .excMisalign(excMisalign),
  .notHandled(notHandled)
);

// File: tb/insn_exec_unit_bench.sv
module insn_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0, pc = '0, srcA = '0, srcB = '0;
  logic [4:0]  destIdx;
  logic        destWe, flowTaken, memRd, memWr, excIllegal, excMisalign, notHandled;
  logic [31:0] destVal, flowTarget, memAddr, memData;
  logic [1:0]  memSize;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  insn_exec_unit u_insn_exec_unit (
    .clk(clk), .rstN(rstN), .instr(instr), .pc(pc), .srcA(srcA), .srcB(srcB),
    .destIdx(destIdx), .destWe(destWe), .destVal(destVal), .flowTaken(flowTaken),
    .flowTarget(flowTarget), .memRd(memRd), .memWr(memWr), .memSize(memSize),
    .memAddr(memAddr), .memData(memData), .excIllegal(excIllegal),
    .excMisalign(excMisalign), .notHandled(notHandled)
  );

  function automatic logic [31:0] enc(input logic [5:0] k, input logic [2:0] s,
      input logic [4:0] d, input logic [4:0] a, input logic [7:0] c, input logic [4:0] b);
    return {k, s, d, a, c, b};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, result captured at the next rising edge,
  // sampled on the falling edge after that
  task automatic run(input logic [31:0] i, input logic [31:0] p,
                     input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; pc = p; srcA = a; srcB = b;
    @(negedge clk);
  endtask

  task automatic testReset();
    instr = enc(6'h10, 3'd4, 5'd3, 5'd1, 8'd0, 5'd2);
    srcA = 32'd5; srcB = 32'd7; pc = 32'h100;
    repeat (3) @(negedge clk);
    chk("R1", "destWe",    {31'd0, destWe},    32'd0);
    chk("R1", "destVal",   destVal,            32'd0);
    chk("R1", "flowTaken", {31'd0, flowTaken}, 32'd0);
    chk("R1", "memRd",     {31'd0, memRd},     32'd0);
    chk("R1", "excIllegal",{31'd0, excIllegal},32'd0);
    rstN = 1'b1;
  endtask

  task automatic aluReg(input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp, input string nm);
    run(enc(6'h10, op, 5'd3, 5'd1, 8'd0, 5'd2), 32'h100, a, b);
    chk("R3", nm, destVal, exp);
    chk("R4", "destWe alu", {31'd0, destWe}, 32'd1);
    chk("R4", "destIdx alu", {27'd0, destIdx}, 32'd3);
  endtask

  task automatic testAluReg();
    aluReg(3'd4, 32'd5, 32'd7, 32'd12, "add");
    aluReg(3'd5, 32'd5, 32'd7, 32'hFFFF_FFFE, "sub");
    aluReg(3'd0, 32'd5, 32'd7, 32'd5, "and");
    aluReg(3'd1, 32'd5, 32'd2, 32'd7, "or");
    aluReg(3'd2, 32'd5, 32'd7, 32'd2, "xor");
    aluReg(3'd3, 32'd1, 32'd4, 32'd16, "shl");
    aluReg(3'd6, 32'hFFFF_FFFF, 32'd1, 32'd1, "slt");
    aluReg(3'd7, 32'hFFFF_FFFF, 32'd1, 32'd0, "sltu");
  endtask

  task automatic testAluLit();
    run(enc(6'h11, 3'd4, 5'd4, 5'd1, 8'hFF, 5'h1F), 32'h100, 32'd10, 32'd1000);
    chk("R3", "addi -1", destVal, 32'd9);
    run(enc(6'h11, 3'd4, 5'd4, 5'd1, 8'h01, 5'h00), 32'h100, 32'd0, 32'd1000);
    chk("R2", "C above B", destVal, 32'd32);
    run(enc(6'h11, 3'd4, 5'd4, 5'd1, 8'h00, 5'd5), 32'h100, 32'd10, 32'd1000);
    chk("R3", "addi ignores srcB", destVal, 32'd15);
    run(enc(6'h11, 3'd7, 5'd4, 5'd1, 8'hFF, 5'h1F), 32'h100, 32'd5, 32'd0);
    chk("R3", "sltu lit", destVal, 32'd1);
  endtask

  task automatic testDestZero();
    run(enc(6'h10, 3'd4, 5'd0, 5'd1, 8'd0, 5'd2), 32'h100, 32'd5, 32'd7);
    chk("R4", "no write to r0", {31'd0, destWe}, 32'd0);
  endtask

  task automatic br(input logic [2:0] cnd, input logic [7:0] c, input logic [4:0] d,
                    input logic [31:0] a, input logic [31:0] b,
                    input logic expTaken, input logic [31:0] expTgt, input string nm);
    run(enc(6'h14, cnd, d, 5'd1, c, 5'd2), 32'h100, a, b);
    chk("R5", {nm, " taken"}, {31'd0, flowTaken}, {31'd0, expTaken});
    if (expTaken) chk("R5", {nm, " target"}, flowTarget, expTgt);
    chk("R5", {nm, " no write"}, {31'd0, destWe}, 32'd0);
  endtask

  task automatic testBranch();
    br(3'd0, 8'h00, 5'd2,  32'd7, 32'd7, 1'b1, 32'h10C, "beq fwd");
    br(3'd0, 8'hFF, 5'h1F, 32'd7, 32'd7, 1'b1, 32'h100, "beq back");
    br(3'd1, 8'h00, 5'd2,  32'd7, 32'd7, 1'b0, 32'h0,   "bne");
    br(3'd2, 8'h00, 5'd2,  32'hFFFF_FFFF, 32'd1, 1'b1, 32'h10C, "blt");
    br(3'd3, 8'h00, 5'd2,  32'hFFFF_FFFF, 32'd1, 1'b0, 32'h0,   "bge");
    br(3'd4, 8'h00, 5'd2,  32'hFFFF_FFFF, 32'd1, 1'b0, 32'h0,   "bltu");
    br(3'd5, 8'h00, 5'd1,  32'hFFFF_FFFF, 32'd1, 1'b1, 32'h108, "bgeu");
    run(enc(6'h14, 3'd6, 5'd2, 5'd1, 8'h00, 5'd2), 32'h100, 32'd7, 32'd7);
    chk("R6", "cond 6 illegal", {31'd0, excIllegal}, 32'd1);
    chk("R6", "cond 6 not taken", {31'd0, flowTaken}, 32'd0);
  endtask

  task automatic testJump();
    run(enc(6'h15, 3'd0, 5'd31, 5'd0, 8'h00, 5'd3), 32'h100, 32'd0, 32'd0);
    chk("R7", "jrel target", flowTarget, 32'h110);
    chk("R7", "jrel link", destVal, 32'h104);
    chk("R7", "jrel idx", {27'd0, destIdx}, 32'd31);
    chk("R7", "jrel we", {31'd0, destWe}, 32'd1);
    run(enc(6'h15, 3'd0, 5'd31, 5'd1, 8'h00, 5'd0), 32'h100, 32'd0, 32'd0);
    chk("R2", "wide A field", flowTarget, 32'h184);
    run(enc(6'h15, 3'd1, 5'd31, 5'd0, 8'h00, 5'd0), 32'h100, 32'd0, 32'd0);
    chk("R2", "wide sub field", flowTarget, 32'h1104);
    run(enc(6'h15, 3'd7, 5'd31, 5'h1F, 8'hFF, 5'h1F), 32'h100, 32'd0, 32'd0);
    chk("R7", "jrel back", flowTarget, 32'h100);
    run(enc(6'h16, 3'd0, 5'd5, 5'd1, 8'h00, 5'd1), 32'h100, 32'h2000, 32'd0);
    chk("R7", "jreg target", flowTarget, 32'h2004);
    chk("R7", "jreg link", destVal, 32'h104);
    chk("R7", "jreg taken", {31'd0, flowTaken}, 32'd1);
    run(enc(6'h16, 3'd0, 5'd5, 5'd1, 8'hFF, 5'h1E), 32'h100, 32'h2000, 32'd0);
    chk("R7", "jreg back", flowTarget, 32'h1FF8);
  endtask

  task automatic testUpper();
    run(enc(6'h17, 3'd0, 5'd7, 5'd0, 8'h80, 5'd0), 32'h100, 32'd0, 32'd0);
    chk("R8", "upper C", destVal, 32'h8000_0000);
    run(enc(6'h17, 3'd0, 5'd7, 5'd0, 8'h00, 5'd1), 32'h100, 32'd0, 32'd0);
    chk("R8", "upper B", destVal, 32'h0000_0800);
    run(enc(6'h17, 3'd0, 5'd7, 5'd1, 8'h00, 5'd0), 32'h100, 32'd0, 32'd0);
    chk("R8", "upper A", destVal, 32'h0001_0000);
    run(enc(6'h18, 3'd7, 5'd7, 5'h1F, 8'hFF, 5'h1E), 32'h1000, 32'd0, 32'd0);
    chk("R8", "pcrel neg", destVal, 32'hFFE);
    run(enc(6'h18, 3'd0, 5'd7, 5'd0, 8'h00, 5'd5), 32'h1000, 32'd0, 32'd0);
    chk("R8", "pcrel pos", destVal, 32'h1005);
    chk("R8", "pcrel we", {31'd0, destWe}, 32'd1);
  endtask

  task automatic testLoad();
    run(enc(6'h12, 3'd2, 5'd6, 5'd1, 8'h00, 5'd8), 32'h100, 32'h100, 32'd0);
    chk("R9", "ldw rd", {31'd0, memRd}, 32'd1);
    chk("R9", "ldw addr", memAddr, 32'h108);
    chk("R9", "ldw size", {30'd0, memSize}, 32'd2);
    chk("R9", "ldw no we", {31'd0, destWe}, 32'd0);
    chk("R9", "ldw no wr", {31'd0, memWr}, 32'd0);
    run(enc(6'h12, 3'd2, 5'd6, 5'd1, 8'hFF, 5'h1C), 32'h100, 32'h100, 32'd0);
    chk("R9", "ldw neg addr", memAddr, 32'hFC);
    run(enc(6'h12, 3'd0, 5'd6, 5'd1, 8'h00, 5'd1), 32'h100, 32'h100, 32'd0);
    chk("R11", "ldb odd ok", {31'd0, memRd}, 32'd1);
    chk("R11", "ldb odd no exc", {31'd0, excMisalign}, 32'd0);
    run(enc(6'h12, 3'd1, 5'd6, 5'd1, 8'h00, 5'd3), 32'h100, 32'h100, 32'd0);
    chk("R11", "ldh odd exc", {31'd0, excMisalign}, 32'd1);
    chk("R11", "ldh odd no rd", {31'd0, memRd}, 32'd0);
    run(enc(6'h12, 3'd1, 5'd6, 5'd1, 8'h00, 5'd2), 32'h100, 32'h100, 32'd0);
    chk("R11", "ldh even ok", {31'd0, memRd}, 32'd1);
    run(enc(6'h12, 3'd2, 5'd6, 5'd1, 8'h00, 5'd2), 32'h100, 32'h100, 32'd0);
    chk("R11", "ldw half-aligned exc", {31'd0, excMisalign}, 32'd1);
    run(enc(6'h12, 3'd3, 5'd6, 5'd1, 8'h00, 5'd0), 32'h100, 32'h100, 32'd0);
    chk("R12", "size 3 illegal", {31'd0, excIllegal}, 32'd1);
    chk("R12", "size 3 no rd", {31'd0, memRd}, 32'd0);
  endtask

  task automatic testStore();
    run(enc(6'h13, 3'd2, 5'd4, 5'd1, 8'h00, 5'h1F), 32'h100, 32'h200, 32'hDEAD_BEEF);
    chk("R10", "stw wr", {31'd0, memWr}, 32'd1);
    chk("R10", "stw addr from D", memAddr, 32'h204);
    chk("R10", "stw data", memData, 32'hDEAD_BEEF);
    chk("R10", "stw no we", {31'd0, destWe}, 32'd0);
    run(enc(6'h13, 3'd1, 5'd1, 5'd1, 8'h00, 5'd2), 32'h100, 32'h200, 32'd5);
    chk("R11", "sth odd exc", {31'd0, excMisalign}, 32'd1);
    chk("R11", "sth odd no wr", {31'd0, memWr}, 32'd0);
    run(enc(6'h13, 3'd0, 5'd1, 5'd1, 8'h00, 5'd2), 32'h100, 32'h200, 32'd5);
    chk("R10", "stb odd wr", {31'd0, memWr}, 32'd1);
    chk("R10", "stb size", {30'd0, memSize}, 32'd0);
  endtask

  task automatic testIllegal();
    logic [5:0] kinds [3] = '{6'h00, 6'h3F, 6'h1C};
    foreach (kinds[k]) begin
      run(enc(kinds[k], 3'd4, 5'd3, 5'd1, 8'h00, 5'd2), 32'h100, 32'd5, 32'd7);
      chk("R12", "bad kind exc", {31'd0, excIllegal}, 32'd1);
      chk("R12", "bad kind no we", {31'd0, destWe}, 32'd0);
      chk("R12", "bad kind no mem", {30'd0, memRd, memWr}, 32'd0);
      chk("R12", "bad kind no flow", {31'd0, flowTaken}, 32'd0);
    end
    run(enc(6'h10, 3'd4, 5'd3, 5'd1, 8'h00, 5'd2), 32'h100, 32'd5, 32'd7);
    chk("R12", "exc clears", {31'd0, excIllegal}, 32'd0);
  endtask

  task automatic testUnhandled();
    for (int k = 6'h19; k <= 6'h1B; k++) begin
      run(enc(6'(k), 3'd0, 5'd3, 5'd1, 8'h00, 5'd2), 32'h100, 32'd5, 32'd7);
      chk("R13", "not handled", {31'd0, notHandled}, 32'd1);
      chk("R13", "not illegal", {31'd0, excIllegal}, 32'd0);
      chk("R13", "no write", {31'd0, destWe}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testAluReg();
    testAluLit();
    testDestZero();
    testBranch();
    testJump();
    testUpper();
    testLoad();
    testStore();
    testIllegal();
    testUnhandled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule